// File: doc/BRIEF.md
# Stacked-Band Multicarrier PWM Comparator for a Seven-Level Leg

This block produces the comparator pattern that drives one phase leg of a seven-level clamped converter. One up/down counter forms a triangular ramp. From that ramp the block derives six carriers, each in its own band of equal height. Stacked, the bands cover the whole signed reference range with no overlap. Each band compares its carrier with a registered copy of the signed reference. The six results, in thermometer form, are the gate pattern. Their population count is the output level index, from 0 to 6.

The band phasing can be changed at run time. All bands can run in phase. The bands below zero can run in antiphase to those above zero. Or every band can run in antiphase to its neighbours. A second select swaps the plain triangle for a trapezoid: the ramp is amplified by a gain parameter and then clipped to the band, so the carrier stays flat near both extremes. A one-cycle strobe marks the carrier peak. The reference is captured only on that strobe, so the upstream modulator can compute its next sample for a whole carrier period. Dead-time, the mapping of levels to switches and the power stage are handled elsewhere.

Top module: `lspwm_leg`

## Requirements
- R1: The ramp counter leaves reset at 0, rises by one per clock to H = CLK_HZ/(2*CARRIER_HZ), then falls by one per clock to 0 and repeats, giving a period of 2*H clocks. `peak_stb` is 1 exactly in the cycles where the counter equals H. The first such cycle is H clocks after reset is released.
- R2: Band k (k = 0 is the lowest) has the floor F_k = k*H - 3*H. Its carrier is F_k + v_k, with v_k between 0 and H. Bit k of `gate_cmp` is 1 only when the sampled reference is strictly greater than carrier k.
- R3: With `arr_sel` = 0, and also with the unused code 3, every band uses v_k = s, where s is the shaped ramp value.
- R4: With `arr_sel` = 1, bands 0 to 2 (below zero) use v_k = H - s, and bands 3 to 5 use v_k = s.
- R5: With `arr_sel` = 2, odd-numbered bands use v_k = H - s, and even-numbered bands use v_k = s.
- R6: With `trap_en` = 0, s equals the counter c. With `trap_en` = 1, s = min(H, max(0, K*c - (K-1)*H/2)), where K is the gain parameter.
- R7: The reference is sampled into the block only at the clock edge that ends a cycle in which `peak_stb` is 1. Changes to `ref_in` at any other time have no effect on the outputs.
- R8: `gate_cmp` and `level` are registered. The values in cycle t come from the counter, sampled reference and selects of cycle t-1.
- R9: `level` equals the number of set bits in `gate_cmp`, and `gate_cmp` is always a thermometer code (set bits fill from bit 0 upward).
- R10: While the sampled reference and both selects stay unchanged, `level` moves by at most one step per clock.
- R11: While `rst_n` is low, `gate_cmp`, `level` and `peak_stb` are all 0. After reset the sampled reference is 0.
- R12: A sampled reference of -3*H or less keeps `level` at 0 for the whole period. A sampled reference above 3*H keeps `level` at 6. A reference of exactly +3*H clears bit 5 only in the cycles where carrier 5 sits at its top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | REF_W | Signed reference sample |
| arr_sel | input | 2 | Band phasing: 0 in phase, 1 upper/lower opposed, 2 alternately opposed, 3 as 0 |
| trap_en | input | 1 | 1 selects the clipped trapezoidal carrier |
| gate_cmp | output | LEVELS-1 | Registered per-band comparator bits, thermometer-coded |
| level | output | clog2(LEVELS) | Registered count of set comparator bits |
| peak_stb | output | 1 | High in the cycle the ramp sits at its top |

## Verification
The bench builds the block with CLK_HZ = 32000 and CARRIER_HZ = 1000, so H = 16 and a full carrier period takes only 32 clocks. Every ramp value, both clipped plateaus of the trapezoid (with K = 2) and every arrangement can therefore be swept many times in a short run. REF_W = 8 leaves room for references beyond ±3*H, which exercises full-scale saturation in both directions. A reference that changes in the middle of a period checks that the value is captured only at the peak.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

   typedef enum logic [1:0] {
      ARR_SAME  = 2'd0,
      ARR_SPLIT = 2'd1,
      ARR_ALT   = 2'd2,
      ARR_RSVD  = 2'd3
   } arr_e;

   // Whether band k runs in antiphase for the given arrangement.
   function automatic logic band_flip(arr_e arr, int k, int nb);
      case (arr)
         ARR_SPLIT: return (k < nb / 2);
         ARR_ALT:   return (k % 2 == 1);
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/lspwm_ramp.sv
module lspwm_ramp #(
   parameter int H  = 1000,
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output logic          peak
);
   localparam logic [CW-1:0] TOP = CW'(H);

   logic up;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (up) begin
         if (cnt == TOP) begin
            up  <= 1'b0;
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign peak = rst_n && (cnt == TOP);

endmodule

// File: rtl/lspwm_shape.sv
module lspwm_shape #(
   parameter int H      = 1000,
   parameter int CW     = 10,
   parameter int TRAP_K = 2
) (
   input  logic [CW-1:0] cnt,
   input  logic          trap_en,
   output logic [CW-1:0] s
);
   localparam int SW = CW + $clog2(TRAP_K) + 2;
   localparam logic signed [SW-1:0] K_S   = SW'(TRAP_K);
   localparam logic signed [SW-1:0] OFF_S = SW'((TRAP_K - 1) * H / 2);
   localparam logic signed [SW-1:0] TOP_S = SW'(H);

   logic signed [SW-1:0] lin;

   always_comb begin
      lin = $signed(SW'(cnt)) * K_S - OFF_S;
      if (!trap_en)
         s = cnt;
      else if (lin < 0)
         s = '0;
      else if (lin > TOP_S)
         s = CW'(H);
      else
         s = CW'(lin);
   end

endmodule

// File: rtl/lspwm_band.sv
module lspwm_band #(
   parameter int REF_W = 16,
   parameter int CW    = 10,
   parameter int H     = 1000,
   parameter int NB    = 6,
   parameter int IDX   = 0
) (
   input  logic signed [REF_W-1:0] ref_q,
   input  logic        [CW-1:0]    s,
   input  logic                    flip,
   output logic                    hit
);
   localparam logic signed [REF_W-1:0] FLOOR = REF_W'(IDX * H - (NB / 2) * H);

   logic        [CW-1:0]    v;
   logic signed [REF_W-1:0] car;

   always_comb begin
      v   = flip ? (CW'(H) - s) : s;
      car = FLOOR + $signed(REF_W'(v));
      hit = (ref_q > car);
   end

endmodule

// File: rtl/lspwm_leg.sv
module lspwm_leg
   import lspwm_pkg::*;
#(
   parameter int CLK_HZ     = 2_700_000,
   parameter int CARRIER_HZ = 1350,
   parameter int LEVELS     = 7,
   parameter int REF_W      = 16,
   parameter int TRAP_K     = 2,
   localparam int NB        = LEVELS - 1,
   localparam int LW        = $clog2(LEVELS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic        [1:0]       arr_sel,
   input  logic                    trap_en,
   output logic        [NB-1:0]    gate_cmp,
   output logic        [LW-1:0]    level,
   output logic                    peak_stb
);
   localparam int H  = CLK_HZ / (2 * CARRIER_HZ);
   localparam int CW = $clog2(H + 1);

   // elaboration-time parameter checks
   if (LEVELS < 3 || LEVELS % 2 == 0) begin : g_bad_levels
      $error("LEVELS must be odd and at least 3");
   end
   if (H < 2 || H % 2 != 0) begin : g_bad_half
      $error("CLK_HZ/(2*CARRIER_HZ) must be even and at least 2");
   end
   if (TRAP_K < 2) begin : g_bad_gain
      $error("TRAP_K must be at least 2");
   end
   if ((NB / 2) * H >= (1 << (REF_W - 1))) begin : g_bad_refw
      $error("REF_W too narrow for the stacked band range");
   end

   logic [CW-1:0]           cnt;
   logic [CW-1:0]           shaped;
   logic signed [REF_W-1:0] ref_q;
   logic [NB-1:0]           flip;
   logic [NB-1:0]           hit;
   logic [LW-1:0]           lvl_d;
   arr_e                    arr;

   assign arr = arr_e'(arr_sel);

   lspwm_ramp #(.H(H), .CW(CW)) i_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .peak  (peak_stb)
   );

   lspwm_shape #(.H(H), .CW(CW), .TRAP_K(TRAP_K)) i_shape (
      .cnt     (cnt),
      .trap_en (trap_en),
      .s       (shaped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ref_q <= '0;
      else if (peak_stb)
         ref_q <= ref_in;
   end

   for (genvar k = 0; k < NB; k++) begin : g_band
      assign flip[k] = band_flip(arr, k, NB);
      lspwm_band #(
         .REF_W (REF_W),
         .CW    (CW),
         .H     (H),
         .NB    (NB),
         .IDX   (k)
      ) i_band (
         .ref_q (ref_q),
         .s     (shaped),
         .flip  (flip[k]),
         .hit   (hit[k])
      );
   end

   assign lvl_d = LW'($countones(hit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_cmp <= '0;
         level    <= '0;
      end else begin
         gate_cmp <= hit;
         level    <= lvl_d;
      end
   end

endmodule

// File: rtl/lspwm_leg_chk.sv
module lspwm_leg_chk #(
   parameter int NB     = 6,
   parameter int LW     = 3,
   parameter int PERIOD = 2000,
   parameter int REF_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [REF_W-1:0] ref_in,
   input logic signed [REF_W-1:0] ref_q,
   input logic        [1:0]       arr_sel,
   input logic                    trap_en,
   input logic        [NB-1:0]    gate_cmp,
   input logic        [LW-1:0]    level,
   input logic                    peak_stb
);
   int                        gap;
   logic                      seen;
   logic [REF_W+2:0]          key_prev;
   logic [1:0]                stab;
   logic [REF_W+2:0]          key_now;

   assign key_now = {ref_q, arr_sel, trap_en};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap      <= 0;
         seen     <= 1'b0;
         key_prev <= '0;
         stab     <= '0;
      end else begin
         if (peak_stb) begin
            gap  <= 1;
            seen <= 1'b1;
         end else begin
            gap <= gap + 1;
         end
         key_prev <= key_now;
         if (key_now != key_prev)
            stab <= '0;
         else if (stab != 2'd2)
            stab <= stab + 1'b1;
      end
   end

   AST_PEAK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_stb && seen) |-> (gap == PERIOD));                              // R1
   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_stb |=> $stable(ref_q));                                        // R7
   AST_REF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      peak_stb |=> (ref_q == $past(ref_in)));                               // R7
   AST_THERMO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_cmp & (gate_cmp + NB'(1))) == '0);                              // R9
   AST_LEVEL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) == $countones(gate_cmp));                                 // R9
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (stab == 2'd2) |-> ((int'(level) - int'($past(level)) <= 1) &&
                          (int'($past(level)) - int'(level) <= 1)));        // R10
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (gate_cmp == '0 && level == '0));                          // R11

endmodule

bind lspwm_leg lspwm_leg_chk #(
   .NB     (NB),
   .LW     (LW),
   .PERIOD (2 * H),
   .REF_W  (REF_W)
) i_lspwm_leg_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ref_in   (ref_in),
   .ref_q    (ref_q),
   .arr_sel  (arr_sel),
   .trap_en  (trap_en),
   .gate_cmp (gate_cmp),
   .level    (level),
   .peak_stb (peak_stb)
);

// File: tb/test_lspwm_leg.sv
module test_lspwm_leg;

   localparam int CLK_HZ     = 32000;
   localparam int CARRIER_HZ = 1000;
   localparam int LEVELS     = 7;
   localparam int REF_W      = 8;
   localparam int TRAP_K     = 2;
   localparam int NB         = LEVELS - 1;
   localparam int LW         = $clog2(LEVELS);
   localparam int H          = CLK_HZ / (2 * CARRIER_HZ);

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic signed [REF_W-1:0] ref_in;
   logic        [1:0]       arr_sel;
   logic                    trap_en;
   logic        [NB-1:0]    gate_cmp;
   logic        [LW-1:0]    level;
   logic                    peak_stb;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   // bench model state
   int   cnt_m, ref_q_m, nsteps;
   bit   up_m;
   int   kref_last, karr_last, ktrap_last;
   int   lvl_prev;

   always #2 clk = ~clk;

   lspwm_leg #(
      .CLK_HZ     (CLK_HZ),
      .CARRIER_HZ (CARRIER_HZ),
      .LEVELS     (LEVELS),
      .REF_W      (REF_W),
      .TRAP_K     (TRAP_K)
   ) i_lspwm_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_in   (ref_in),
      .arr_sel  (arr_sel),
      .trap_en  (trap_en),
      .gate_cmp (gate_cmp),
      .level    (level),
      .peak_stb (peak_stb)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // expected comparator pattern from the band rules
   function automatic logic [NB-1:0] exp_cmp(int r, int c, logic [1:0] a, logic t);
      logic [NB-1:0] e;
      int s, lin, v, car;
      bit fl;
      if (t) begin
         lin = TRAP_K * c - (TRAP_K - 1) * H / 2;
         s = (lin < 0) ? 0 : ((lin > H) ? H : lin);
      end else begin
         s = c;
      end
      for (int k = 0; k < NB; k++) begin
         fl   = (a == 2'd1 && k < NB / 2) || (a == 2'd2 && (k % 2) == 1);
         v    = fl ? (H - s) : s;
         car  = k * H - (NB / 2) * H + v;
         e[k] = (r > car);
      end
      return e;
   endfunction

   function automatic int ones(logic [NB-1:0] x);
      int n = 0;
      for (int k = 0; k < NB; k++) n += int'(x[k]);
      return n;
   endfunction

   task automatic model_reset();
      cnt_m = 0; up_m = 1'b1; ref_q_m = 0; nsteps = 0;
      kref_last = 0; karr_last = 0; ktrap_last = 0; lvl_prev = 0;
   endtask

   // one clock: predict, advance model, compare at the falling edge
   task automatic step(input string tag);
      logic [NB-1:0] e;
      bit cond;
      e = exp_cmp(ref_q_m, cnt_m, arr_sel, trap_en);
      cond = (nsteps >= 1) && (ref_q_m == kref_last) &&
             (int'(arr_sel) == karr_last) && (int'(trap_en) == ktrap_last);
      kref_last  = ref_q_m;
      karr_last  = int'(arr_sel);
      ktrap_last = int'(trap_en);
      @(posedge clk);
      if (cnt_m == H) ref_q_m = int'(ref_in);
      if (up_m) begin
         if (cnt_m == H) begin up_m = 1'b0; cnt_m = cnt_m - 1; end
         else cnt_m = cnt_m + 1;
      end else begin
         if (cnt_m == 0) begin up_m = 1'b1; cnt_m = cnt_m + 1; end
         else cnt_m = cnt_m - 1;
      end
      @(negedge clk);
      chk(gate_cmp == e, {tag, " R8 gate_cmp"}, int'(gate_cmp), int'(e));
      chk(int'(level) == ones(e), "R9 level", int'(level), ones(e));
      chk(peak_stb == (cnt_m == H), "R1 peak_stb", int'(peak_stb), int'(cnt_m == H));
      if (cond) begin
         chk((int'(level) - lvl_prev <= 1) && (lvl_prev - int'(level) <= 1),
             "R10 level step", int'(level), lvl_prev);
      end
      lvl_prev = int'(level);
      nsteps++;
   endtask

   task automatic run(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ref_in = 8'sd30; arr_sel = 2'd0; trap_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         ref_in = 8'(i * 11 - 20);
         chk(gate_cmp == '0, "R11 gate_cmp in reset", int'(gate_cmp), 0);
         chk(level == '0, "R11 level in reset", int'(level), 0);
         chk(peak_stb == 1'b0, "R11 peak in reset", int'(peak_stb), 0);
      end
      ref_in = 8'sd0;
      rst_n  = 1'b1;
      model_reset();
      // first peak H clocks after release (R1)
      for (int i = 0; i < H; i++) step("R1");
      chk(peak_stb == 1'b1, "R1 first peak", int'(peak_stb), 1);
   endtask

   task automatic t_same();
      arr_sel = 2'd0; trap_en = 1'b0;
      ref_in = 8'sd0;   run("R2 R3", 2 * 2 * H);
      ref_in = 8'sd20;  run("R2 R3", 2 * 2 * H);
      ref_in = -8'sd37; run("R2 R3", 2 * 2 * H);
      arr_sel = 2'd3; ref_in = 8'sd9; run("R3 code3", 2 * 2 * H);
   endtask

   task automatic t_split();
      arr_sel = 2'd1; trap_en = 1'b0;
      ref_in = 8'sd10;  run("R4", 2 * 2 * H);
      ref_in = -8'sd25; run("R4", 2 * 2 * H);
   endtask

   task automatic t_alt();
      arr_sel = 2'd2; trap_en = 1'b0;
      ref_in = 8'sd33;  run("R5", 2 * 2 * H);
      ref_in = -8'sd5;  run("R5", 2 * 2 * H);
   endtask

   task automatic t_trap();
      trap_en = 1'b1;
      arr_sel = 2'd0; ref_in = 8'sd3;   run("R6", 2 * 2 * H);
      arr_sel = 2'd2; ref_in = -8'sd19; run("R6", 2 * 2 * H);
      arr_sel = 2'd1; ref_in = 8'sd41;  run("R6", 2 * 2 * H);
      trap_en = 1'b0;
   endtask

   task automatic t_hold();
      arr_sel = 2'd0;
      for (int i = 0; i < 3 * 2 * H; i++) begin
         if (i % 5 == 0) ref_in = 8'((i * 7) % 90 - 45);
         step("R7");
      end
   endtask

   task automatic t_edges();
      arr_sel = 2'd0; trap_en = 1'b0;
      ref_in = 8'(3 * H);      run("R12 top", 3 * 2 * H);
      ref_in = 8'(3 * H + 1);  run("R12 above", 2 * 2 * H);
      chk(level == 3'd6, "R12 level full", int'(level), 6);
      ref_in = 8'(-3 * H);     run("R12 bottom", 2 * 2 * H);
      chk(level == 3'd0, "R12 level empty", int'(level), 0);
      ref_in = -8'sd60;        run("R12 below", 2 * 2 * H);
      chk(level == 3'd0, "R12 level below", int'(level), 0);
   endtask

   initial begin
      t_reset();
      t_same();
      t_split();
      t_alt();
      t_trap();
      t_hold();
      t_edges();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule